// File: doc/BRIEF.md
# Branch Tag Allocator with Ordered Squash

This block hands out branch tags to the front end of an out-of-order core. Every instruction entering the window is labelled with the current tag. When dispatch sees a predicted branch it asks for a fresh tag. The block takes the lowest-numbered free tag from a bitmap pool and appends it to an age-ordered list of live tags. From then on that tag is the current one. Tag values say nothing about age. Only the position of a tag in the list tells which tags are younger.

On a misprediction the block receives the tag the mispredicted branch was stamped with. Every tag behind it in the list belongs to the wrong path. These tags are broadcast as invalidations, one per cycle, youngest first. Each broadcast tag goes back to the pool. Each reservation-station entry compares its own tag with the broadcast tag and raises its squash line on a match. While this walk is in progress, dispatch is stalled and the current tag shows the mispredicted branch's tag. Dispatch is also stalled whenever the pool is empty.

When a branch resolves correctly and its tag is the oldest live tag, that tag returns to the pool, provided at least one other tag stays live.

Top module: `bt_tag_manager`

## Requirements
- R1: After reset exactly tag 0 is live and current. The stall output is low and no invalidation is broadcast.
- R2: A tag request is granted in the same cycle when the block is not stalled and no misprediction is presented. The granted tag is the lowest-numbered free tag, and it becomes the current tag from the next cycle.
- R3: When all NUM_TAGS tags are live, the stall output is high and a request is not granted.
- R4: A correct resolve frees the oldest live tag when the resolve tag equals that tag and at least two tags are live. The list then shifts by one. A resolve of any other tag, or one presented together with a misprediction or during a squash, changes nothing.
- R5: A misprediction whose tag is live and has younger tags starts a squash. From the next cycle, one younger tag per cycle is broadcast with the invalidate-valid output high, youngest first. Each broadcast tag is free in the following cycle.
- R6: During a squash the stall output is high, no request is granted, and the current tag equals the mispredicted tag. After the last broadcast the current tag stays the mispredicted tag and normal operation resumes.
- R7: A misprediction is ignored in each of these cases: its tag is not live, its tag is the youngest live tag, or a squash is already running. A misprediction blocks a request presented in the same cycle.
- R8: Entry squash bit i is high in exactly the cycles where an invalidation is broadcast and entry i's tag (bits i*TAG_W upward of the entry-tag bus) equals the broadcast tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Dispatch requests a tag for a predicted branch |
| br_grant | output | 1 | Request granted this cycle |
| br_tag | output | TAG_W | Tag being granted (lowest free) |
| cur_tag | output | TAG_W | Tag stamped on instructions now entering |
| stall | output | 1 | Pool empty or squash in progress |
| resolve_ok | input | 1 | A branch resolved as correctly predicted |
| resolve_tag | input | TAG_W | Tag the resolved branch carries |
| mispred | input | 1 | A branch resolved as mispredicted |
| mispred_tag | input | TAG_W | Tag the mispredicted branch carries |
| inv_valid | output | 1 | Invalidation broadcast this cycle |
| inv_tag | output | TAG_W | Tag being invalidated |
| ent_tags | input | NUM_ENT*TAG_W | Tags held by reservation-station entries |
| ent_squash | output | NUM_ENT | Per-entry squash indication |

## Verification
Grant, granted tag, stall and entry squash respond in the same cycle as their inputs. The current tag and the pool change after the next rising edge. The first invalidation of a squash appears in the cycle after the misprediction is sampled, and further invalidations follow one per cycle. The bench drives inputs on the falling edge and compares all outputs 1 ns later against values derived from the model's pre-edge state. It advances its queue-based model only at the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic {
        MODE_RUN    = 1'b0,
        MODE_SQUASH = 1'b1
    } bt_mode_e;
endpackage

// File: rtl/bt_first_free.sv
module bt_first_free #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/bt_inval_match.sv
module bt_inval_match #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inv_valid,
    input  logic [TAG_W-1:0]         inv_tag,
    input  logic [NUM_ENT*TAG_W-1:0] ent_tags,
    output logic [NUM_ENT-1:0]       ent_squash
);
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign ent_squash[e] = inv_valid && (ent_tags[e*TAG_W +: TAG_W] == inv_tag);
    end

    // R8
    squash_needs_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ent_squash) |-> inv_valid);
endmodule

// File: rtl/bt_tag_manager.sv
module bt_tag_manager
    import bt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int NUM_ENT  = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      br_req,
    output logic                                      br_grant,
    output logic [$clog2(NUM_TAGS)-1:0]               br_tag,
    output logic [$clog2(NUM_TAGS)-1:0]               cur_tag,
    output logic                                      stall,
    input  logic                                      resolve_ok,
    input  logic [$clog2(NUM_TAGS)-1:0]               resolve_tag,
    input  logic                                      mispred,
    input  logic [$clog2(NUM_TAGS)-1:0]               mispred_tag,
    output logic                                      inv_valid,
    output logic [$clog2(NUM_TAGS)-1:0]               inv_tag,
    input  logic [NUM_ENT*$clog2(NUM_TAGS)-1:0]       ent_tags,
    output logic [NUM_ENT-1:0]                        ent_squash
);
    localparam int TAG_W = $clog2(NUM_TAGS);
    localparam int CNT_W = $clog2(NUM_TAGS + 1);

    typedef struct packed {
        logic [NUM_TAGS-1:0][TAG_W-1:0] order;
        logic [CNT_W-1:0]               cnt;
        logic [NUM_TAGS-1:0]            free;
        bt_mode_e                       mode;
        logic [TAG_W-1:0]               target;
    } state_t;

    state_t q, d;

    logic             ff_found;
    logic [TAG_W-1:0] ff_idx;
    logic [TAG_W-1:0] tail_idx, prev_idx;
    logic             hit;
    logic [TAG_W-1:0] hit_idx;
    logic             pop;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] cnt_m1;

    bt_first_free #(.N(NUM_TAGS), .W(TAG_W)) u_ff (
        .vec   (q.free),
        .found (ff_found),
        .idx   (ff_idx)
    );

    assign cnt_m1   = q.cnt - CNT_W'(1);
    assign tail_idx = cnt_m1[TAG_W-1:0];
    assign prev_idx = tail_idx - TAG_W'(1);

    // locate the mispredicted tag in the age list
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (!hit && (CNT_W'(i) < q.cnt) && (q.order[i] == mispred_tag)) begin
                hit     = 1'b1;
                hit_idx = TAG_W'(i);
            end
        end
    end

    assign stall     = (q.mode == MODE_SQUASH) || !ff_found;
    assign br_grant  = br_req && !stall && !mispred;
    assign br_tag    = ff_idx;
    assign inv_valid = (q.mode == MODE_SQUASH);
    assign inv_tag   = q.order[tail_idx];
    assign cur_tag   = (q.mode == MODE_SQUASH) ? q.target : q.order[tail_idx];

    always_comb begin
        d        = q;
        pop      = 1'b0;
        base_cnt = q.cnt;
        if (q.mode == MODE_SQUASH) begin
            // retire the youngest tag that was broadcast this cycle
            d.free[q.order[tail_idx]] = 1'b1;
            d.cnt = cnt_m1;
            if (q.order[prev_idx] == q.target) d.mode = MODE_RUN;
        end else if (mispred) begin
            if (hit && (hit_idx != tail_idx)) begin
                d.mode   = MODE_SQUASH;
                d.target = mispred_tag;
            end
        end else begin
            pop = resolve_ok && (q.cnt >= CNT_W'(2)) && (resolve_tag == q.order[0]);
            if (pop) begin
                d.free[q.order[0]] = 1'b1;
                for (int i = 0; i < NUM_TAGS - 1; i++) d.order[i] = q.order[i+1];
                base_cnt = cnt_m1;
            end
            if (br_grant) begin
                d.order[base_cnt[TAG_W-1:0]] = ff_idx;
                d.free[ff_idx]               = 1'b0;
            end
            d.cnt = base_cnt + CNT_W'(br_grant);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.order  <= '0;
            q.cnt    <= CNT_W'(1);
            q.free   <= {{(NUM_TAGS-1){1'b1}}, 1'b0};
            q.mode   <= MODE_RUN;
            q.target <= '0;
        end else begin
            q <= d;
        end
    end

    bt_inval_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv_valid  (inv_valid),
        .inv_tag    (inv_tag),
        .ent_tags   (ent_tags),
        .ent_squash (ent_squash)
    );

    // R2 R4
    pool_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q.free) + int'(q.cnt)) == NUM_TAGS);

    // R2
    grant_becomes_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_grant |=> (cur_tag == $past(br_tag)));

    // R5
    inv_frees_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> q.free[$past(inv_tag)]);

    // R6
    squash_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (stall && !br_grant));

    // R5
    inv_not_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_tag != cur_tag));

    // R4
    list_never_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt != '0);
endmodule

// File: tb/sim_bt_tag_manager.sv
module sim_bt_tag_manager;
    localparam int NT = 8;
    localparam int TW = 3;
    localparam int NE = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_req = 1'b0;
    logic             br_grant;
    logic [TW-1:0]    br_tag;
    logic [TW-1:0]    cur_tag;
    logic             stall;
    logic             resolve_ok = 1'b0;
    logic [TW-1:0]    resolve_tag = '0;
    logic             mispred = 1'b0;
    logic [TW-1:0]    mispred_tag = '0;
    logic             inv_valid;
    logic [TW-1:0]    inv_tag;
    logic [NE*TW-1:0] ent_tags = '0;
    logic [NE-1:0]    ent_squash;

    always #5 clk = ~clk;

    bt_tag_manager #(.NUM_TAGS(NT), .NUM_ENT(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_grant(br_grant),
        .br_tag(br_tag), .cur_tag(cur_tag), .stall(stall),
        .resolve_ok(resolve_ok), .resolve_tag(resolve_tag),
        .mispred(mispred), .mispred_tag(mispred_tag),
        .inv_valid(inv_valid), .inv_tag(inv_tag),
        .ent_tags(ent_tags), .ent_squash(ent_squash)
    );

    int lst[$];
    bit [NT-1:0] freev;
    bit sq;
    int tgt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step(string rq, bit req, bit res, int rt, bit mis, int mt);
        bit estall, egnt, pop;
        int ebt, ecur, p;
        bit [NE-1:0] esq;
        br_req      = req;
        resolve_ok  = res;
        resolve_tag = TW'(rt);
        mispred     = mis;
        mispred_tag = TW'(mt);
        ent_tags    = (NE*TW)'($urandom);
        if ($urandom % 2 == 0) ent_tags[TW-1:0] = TW'(lst[$]);
        #1;
        estall = sq || (lst.size() == NT);
        egnt   = req && !estall && !mis;
        ebt    = 0;
        for (int i = NT - 1; i >= 0; i--) if (freev[i]) ebt = i;
        ecur   = sq ? tgt : lst[$];
        for (int e = 0; e < NE; e++)
            esq[e] = sq && (int'(ent_tags[e*TW +: TW]) == lst[$]);
        chk(rq, "stall", int'(stall), int'(estall));
        chk(rq, "grant", int'(br_grant), int'(egnt));
        if (egnt) chk(rq, "br_tag", int'(br_tag), ebt);
        chk(rq, "cur_tag", int'(cur_tag), ecur);
        chk(rq, "inv_valid", int'(inv_valid), int'(sq));
        if (sq) chk(rq, "inv_tag", int'(inv_tag), lst[$]);
        chk(rq, "ent_squash", int'(ent_squash), int'(esq));
        @(posedge clk);
        if (sq) begin
            freev[lst[$]] = 1'b1;
            void'(lst.pop_back());
            if (lst[$] == tgt) sq = 1'b0;
        end else if (mis) begin
            p = -1;
            foreach (lst[i]) if (p < 0 && lst[i] == mt) p = i;
            if (p >= 0 && p < lst.size() - 1) begin
                sq  = 1'b1;
                tgt = mt;
            end
        end else begin
            pop = res && (lst.size() >= 2) && (lst[0] == rt);
            if (pop) begin
                freev[lst[0]] = 1'b1;
                void'(lst.pop_front());
            end
            if (egnt) begin
                lst.push_back(ebt);
                freev[ebt] = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        lst = {0};
        freev = {{(NT-1){1'b1}}, 1'b0};
        sq = 1'b0;
        tgt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "cur_tag", int'(cur_tag), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "inv_valid", int'(inv_valid), 0);
        @(negedge clk);

        // R2 allocate three tags
        repeat (3) step("R2", 1, 0, 0, 0, 0);
        // R4 resolve of a non-oldest tag is ignored, then oldest frees
        step("R4", 0, 1, 2, 0, 0);
        step("R4", 0, 1, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0);
        // R3 fill the pool then request while full
        repeat (4) step("R3", 1, 0, 0, 0, 0);
        step("R3", 1, 0, 0, 0, 0);
        step("R3", 1, 1, lst[0], 0, 0);
        step("R3", 1, 0, 0, 0, 0);
        // R5 squash all tags younger than the second-oldest
        step("R5", 0, 0, 0, 1, lst[1]);
        repeat (6) step("R6", 1, 1, lst[0], 0, 0);
        // R7 mispredict on youngest and on a dead tag
        step("R7", 0, 0, 0, 1, lst[$]);
        for (int t = 0; t < NT; t++) if (freev[t]) begin
            step("R7", 0, 0, 0, 1, t);
            break;
        end
        repeat (2) step("R2", 1, 0, 0, 0, 0);
        // R7 mispredict beats a request, then a mispredict mid-squash is ignored
        step("R7", 1, 0, 0, 1, lst[1]);
        step("R7", 0, 0, 0, 1, lst[0]);
        repeat (3) step("R8", 0, 0, 0, 0, 0);

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            bit rq, rs, ms;
            int rt, mt;
            rq = ($urandom % 10) < 7;
            rs = ($urandom % 10) < 3;
            ms = ($urandom % 20) == 0;
            rt = ($urandom % 3 == 0) ? int'($urandom % NT) : lst[0];
            mt = ($urandom % 2 == 0) ? lst[$urandom % lst.size()] : int'($urandom % NT);
            step("R5", rq, rs, rt, ms, mt);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule